// File: doc/BRIEF.md
# Privilege-Gated Event Counter Bank

This block holds a bank of independent event counters behind an APB register port. Each counter owns a selector that picks one event class out of a wide event vector, narrows it with a sub-event mask, and compares the current execution level against a per-counter scope to decide whether counting is allowed in this cycle. One global enable bit starts and stops all counters together.

Each counter has a status word with a sticky rollover flag and an interrupt-cause flag. The causes are combined into one shared level interrupt. When that interrupt goes from low to high, the program counter presented on the input is captured into a read-only register, so profiling software can see where execution was when the first overflow happened.

Top module: `evt_counter_bank`

## Requirements
- R1: After a synchronous reset every register reads 0 and `irq` is 0.
- R2: Bit 0 of the word at offset 0x000 is the global enable; while it is 0 no counter changes except by a software write.
- R3: Counter n is at 0x080+4n, its selector at 0x100+4n, its status at 0x180+4n (n = 0..7), the captured PC at 0x010; any other address, including slots n >= 8, reads 0.
- R4: Selector fields: bit 0 overflow interrupt enable, bit 3 direction, bits [6:4] scope, bits [12:8] event class, bits [31:16] sub-event mask; every other bit reads 0 (writing all ones reads back 0xFFFF1F79).
- R5: With direction 1 a counter counts only while the execution level is greater than the scope; with direction 0 only while it is less than or equal to the scope.
- R6: Sub-event s of class c is input bit c*16+s; a counter adds exactly 1 in each cycle where any sub-event of its class that is set in its mask is active, however many are active.
- R7: Status bit 0 is set when the counter rolls from 0xFFFFFFFF to 0 and stays set until software writes 0 to it.
- R8: A rollover with the interrupt enable set also sets status bit 4; `irq` is high exactly while any counter's bit 4 is set, and writing 0 to that bit clears it.
- R9: In the cycle where `irq` rises, the current PC is stored into the register at 0x010; software writes to it have no effect.
- R10: A software write to a counter in the same cycle as a qualifying event stores the written value with no increment.
- R11: A rollover with the interrupt enable clear sets status bit 0 only, and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered in the setup phase |
| evt_vec | input | 512 | Event vector, 32 classes of 16 sub-events |
| exec_lvl | input | 3 | Current execution level |
| cur_pc | input | 32 | Current program counter |
| irq | output | 1 | Shared overflow interrupt, level |

## Verification
The assertions assume APB transfers are well formed: a setup cycle with `penable` low, followed by exactly one access cycle, with address and data held across both. They also assume word-aligned addresses and that events, execution level and PC only change between clock edges. The bench drives every input on the falling edge, issues only two-cycle APB transfers, and keeps events quiet while it reads back counters so that each read sees a frozen value.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

  localparam int SUB_W = 16;  // sub-events per class, equals mask width
  localparam int CLS_W = 5;   // event class select width
  localparam int LVL_W = 3;   // execution level / scope width
  localparam int REG_W = 32;  // register data width

  // status bit positions
  localparam int ST_OVF_BIT = 0;
  localparam int ST_INT_BIT = 4;

  // address regions, selected by paddr[ADDR_W-1:7]
  localparam int RGN_CTR = 1;
  localparam int RGN_SEL = 2;
  localparam int RGN_ST  = 3;

  typedef struct packed {
    logic [SUB_W-1:0] mask;   // [31:16]
    logic [2:0]       rsv2;   // [15:13]
    logic [CLS_W-1:0] cls;    // [12:8]
    logic             rsv1;   // [7]
    logic [LVL_W-1:0] scope;  // [6:4]
    logic             dir;    // [3]
    logic [1:0]       rsv0;   // [2:1]
    logic             inten;  // [0]
  } sel_t;

  function automatic sel_t sel_clean(input logic [REG_W-1:0] w);
    sel_t s;
    s      = sel_t'(w);
    s.rsv0 = '0;
    s.rsv1 = 1'b0;
    s.rsv2 = '0;
    return s;
  endfunction

endpackage

// File: rtl/evt_gate.sv
module evt_gate
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CLASS = 32
) (
  input  logic                       en_i,
  input  logic [NUM_CLASS*SUB_W-1:0] evt_vec_i,
  input  logic [LVL_W-1:0]           lvl_i,
  input  sel_t                       sel_i,
  output logic                       hit_o
);

  logic [SUB_W-1:0] grp;
  logic             priv_ok;
  logic             any_sub;

  // pick the class group; out-of-range classes see no events
  always_comb begin
    grp = '0;
    if (int'(sel_i.cls) < NUM_CLASS)
      grp = evt_vec_i[int'(sel_i.cls)*SUB_W +: SUB_W];
  end

  // privilege direction: 1 = strictly above scope, 0 = at or below scope
  always_comb begin
    if (sel_i.dir) priv_ok = (lvl_i > sel_i.scope);
    else           priv_ok = (lvl_i <= sel_i.scope);
  end

  // many masked sub-events collapse to a single count
  assign any_sub = |(grp & sel_i.mask);
  assign hit_o   = en_i & priv_ok & any_sub;

endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CLASS = 32,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       glb_en_i,
  input  logic [NUM_CLASS*SUB_W-1:0] evt_vec_i,
  input  logic [LVL_W-1:0]           lvl_i,
  input  logic                       wr_cnt_i,
  input  logic                       wr_sel_i,
  input  logic                       wr_st_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           cnt_rd_o,
  output logic [REG_W-1:0]           sel_rd_o,
  output logic [REG_W-1:0]           st_rd_o,
  output logic                       flag_nxt_o
);

  logic [CNT_W-1:0] cnt;
  sel_t             sel;
  logic             ovf;
  logic             flag;
  logic             hit;
  logic             wrap;
  logic             ovf_nxt;
  logic             flag_nxt;

  evt_gate #(
    .NUM_CLASS(NUM_CLASS)
  ) u_gate (
    .en_i      (glb_en_i),
    .evt_vec_i (evt_vec_i),
    .lvl_i     (lvl_i),
    .sel_i     (sel),
    .hit_o     (hit)
  );

  // rollover only when hardware increments from all ones
  assign wrap     = !wr_cnt_i && hit && (cnt == {CNT_W{1'b1}});
  // hardware set wins over a same-cycle software clear
  assign ovf_nxt  = (wr_st_i ? wdata_i[ST_OVF_BIT] : ovf) | wrap;
  assign flag_nxt = (wr_st_i ? wdata_i[ST_INT_BIT] : flag) | (wrap & sel.inten);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sel  <= '0;
      ovf  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_cnt_i)  cnt <= wdata_i[CNT_W-1:0];
      else if (hit)  cnt <= cnt + 1'b1;
      if (wr_sel_i)  sel <= sel_clean(wdata_i);
      ovf  <= ovf_nxt;
      flag <= flag_nxt;
    end
  end

  assign flag_nxt_o = flag_nxt;
  assign cnt_rd_o   = REG_W'(cnt);
  assign sel_rd_o   = sel;

  always_comb begin
    st_rd_o             = '0;
    st_rd_o[ST_OVF_BIT] = ovf;
    st_rd_o[ST_INT_BIT] = flag;
  end

  // R2: global enable off freezes the counter unless software writes it
  p_frozen_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!glb_en_i && !wr_cnt_i) |=> (cnt == $past(cnt)));

  // R6: without a write the counter moves by at most one
  p_step_at_most_one_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt_i && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R7: rollover lands on zero with the overflow flag set
  p_wrap_sets_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt_i && hit && cnt == {CNT_W{1'b1}}) |=> (ovf && cnt == '0));

  // R7: overflow flag is sticky until software writes the status word
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_st_i) |=> ovf);

  // R10: a counter write is taken exactly, no increment on top
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_i |=> (cnt == $past(wdata_i[CNT_W-1:0])));

  // R11: the cause flag only rises through software or with the enable set
  p_cause_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(wr_st_i) || $past(sel.inten)));

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR   = 8,
  parameter int NUM_CLASS = 32,
  parameter int CNT_W     = 32,
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [REG_W-1:0]           pwdata,
  output logic [REG_W-1:0]           prdata,
  input  logic [NUM_CLASS*SUB_W-1:0] evt_vec,
  input  logic [LVL_W-1:0]           exec_lvl,
  input  logic [PC_W-1:0]            cur_pc,
  output logic                       irq
);

  localparam int RGN_W         = ADDR_W - 7;
  localparam int IDX_W         = 5;
  localparam logic [ADDR_W-1:0] ADDR_GLB = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] ADDR_PCL = ADDR_W'(12'h010);

  logic                glb_en;
  logic [PC_W-1:0]     pc_lat;
  logic                wr_acc;
  logic                rd_setup;
  logic                aligned;
  logic [RGN_W-1:0]    rgn;
  logic [IDX_W-1:0]    idx;
  logic                idx_ok;
  logic [NUM_CTR-1:0]  wr_cnt;
  logic [NUM_CTR-1:0]  wr_sel;
  logic [NUM_CTR-1:0]  wr_st;
  logic [NUM_CTR-1:0]  flag_nxt;
  logic                irq_nxt;
  logic [REG_W-1:0]    cnt_rd [NUM_CTR];
  logic [REG_W-1:0]    sel_rd [NUM_CTR];
  logic [REG_W-1:0]    st_rd  [NUM_CTR];
  logic [REG_W-1:0]    rd_mux;

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign aligned  = (paddr[1:0] == 2'b00);
  assign rgn      = paddr[ADDR_W-1:7];
  assign idx      = paddr[6:2];
  assign idx_ok   = (int'(idx) < NUM_CTR);

  // per-counter write strobes
  always_comb begin
    for (int k = 0; k < NUM_CTR; k++) begin
      wr_cnt[k] = wr_acc && aligned && (int'(rgn) == RGN_CTR) && (int'(idx) == k);
      wr_sel[k] = wr_acc && aligned && (int'(rgn) == RGN_SEL) && (int'(idx) == k);
      wr_st[k]  = wr_acc && aligned && (int'(rgn) == RGN_ST)  && (int'(idx) == k);
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    evt_counter #(
      .NUM_CLASS(NUM_CLASS),
      .CNT_W    (CNT_W)
    ) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .glb_en_i   (glb_en),
      .evt_vec_i  (evt_vec),
      .lvl_i      (exec_lvl),
      .wr_cnt_i   (wr_cnt[g]),
      .wr_sel_i   (wr_sel[g]),
      .wr_st_i    (wr_st[g]),
      .wdata_i    (pwdata),
      .cnt_rd_o   (cnt_rd[g]),
      .sel_rd_o   (sel_rd[g]),
      .st_rd_o    (st_rd[g]),
      .flag_nxt_o (flag_nxt[g])
    );
  end

  assign irq_nxt = |flag_nxt;

  // global enable, interrupt level and PC capture on the rising edge of irq
  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      irq    <= 1'b0;
      pc_lat <= '0;
    end else begin
      if (wr_acc && paddr == ADDR_GLB) glb_en <= pwdata[0];
      irq <= irq_nxt;
      if (!irq && irq_nxt) pc_lat <= cur_pc;
    end
  end

  // read decode
  always_comb begin
    rd_mux = '0;
    if (paddr == ADDR_GLB) begin
      rd_mux[0] = glb_en;
    end else if (paddr == ADDR_PCL) begin
      rd_mux = REG_W'(pc_lat);
    end else if (aligned && idx_ok) begin
      for (int k = 0; k < NUM_CTR; k++) begin
        if (int'(idx) == k) begin
          if (int'(rgn) == RGN_CTR) rd_mux = cnt_rd[k];
          if (int'(rgn) == RGN_SEL) rd_mux = sel_rd[k];
          if (int'(rgn) == RGN_ST)  rd_mux = st_rd[k];
        end
      end
    end
  end

  // data is registered in the setup phase and held through the access phase
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  // R9: the captured PC is the one present in the cycle irq rose
  p_pc_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (pc_lat == $past(cur_pc)));

  // R9: outside a rising interrupt the captured PC never changes
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irq || !irq_nxt) |=> $stable(pc_lat));

  // R8: irq follows the counters' cause flags one edge later
  p_irq_tracks_causes_r8: assert property (@(posedge clk) disable iff (rst)
    (!irq_nxt) |=> !irq);

endmodule

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;
  import evt_ctr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCLS       = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              psel, penable, pwrite;
  logic [11:0]       paddr;
  logic [31:0]       pwdata;
  logic [31:0]       prdata;
  logic [NCLS*16-1:0] evt_vec;
  logic [2:0]        exec_lvl;
  logic [31:0]       cur_pc;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_counter_bank u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt_vec(evt_vec),
    .exec_lvl(exec_lvl), .cur_pc(cur_pc), .irq(irq)
  );

  function automatic logic [11:0] a_cnt(int n); return 12'h080 + 12'(4*n); endfunction
  function automatic logic [11:0] a_sel(int n); return 12'h100 + 12'(4*n); endfunction
  function automatic logic [11:0] a_st (int n); return 12'h180 + 12'(4*n); endfunction

  function automatic logic [31:0] mk_sel(logic [15:0] m, int cls, int scope, bit dir, bit inten);
    return {m, 3'b000, 5'(cls), 1'b0, 3'(scope), dir, 2'b00, inten};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  // hold the current events for exactly k rising edges, then clear them
  task automatic pulse_evt(logic [NCLS*16-1:0] v, int k);
    @(negedge clk);
    evt_vec = v;
    repeat (k) @(negedge clk);
    evt_vec = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    evt_vec = '0; exec_lvl = 3'd0; cur_pc = 32'h0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    apb_rd(12'h000, rd); chk("R1 enable", rd, 32'h0);
    apb_rd(12'h010, rd); chk("R1 pc", rd, 32'h0);
    for (int n = 0; n < 8; n++) begin
      apb_rd(a_cnt(n), rd); chk("R1 counter", rd, 32'h0);
      apb_rd(a_sel(n), rd); chk("R1 selector", rd, 32'h0);
      apb_rd(a_st(n),  rd); chk("R1 status", rd, 32'h0);
    end

    // R4: reserved selector bits read as zero
    apb_wr(a_sel(5), 32'hFFFF_FFFF);
    apb_rd(a_sel(5), rd); chk("R4 reserved", rd, 32'hFFFF_1F79);
    apb_wr(a_sel(5), 32'h0);

    // R2: global enable off, events do nothing
    apb_wr(a_sel(0), mk_sel(16'hFFFF, 0, 7, 1'b0, 1'b0));
    pulse_evt({{(NCLS-1)*16{1'b0}}, 16'hFFFF}, 4);
    apb_rd(a_cnt(0), rd); chk("R2 disabled", rd, 32'h0);
    apb_wr(12'h000, 32'h1);
    apb_rd(12'h000, rd); chk("R2 enable readback", rd, 32'h1);
    pulse_evt({{(NCLS-1)*16{1'b0}}, 16'hFFFF}, 4);
    apb_rd(a_cnt(0), rd); chk("R2 enabled", rd, 32'h4);
    apb_wr(a_sel(0), 32'h0);

    // R6 / R3: sweep every class, rotating through all counter slots
    for (int c = 0; c < NCLS; c++) begin
      int n = c % 8;
      logic [15:0] m;
      logic [NCLS*16-1:0] v;
      m = (16'h1 << (c % 16)) | (16'h1 << ((c + 5) % 16));
      for (int k = 0; k < 8; k++) apb_wr(a_sel(k), 32'h0);
      apb_wr(a_cnt(n), 32'h0);
      apb_wr(a_sel(n), mk_sel(m, c, 7, 1'b0, 1'b0));
      v = '0; v[c*16 +: 16] = 16'hFFFF;           // several masked hits at once
      pulse_evt(v, 3);
      v = '1; v[c*16 +: 16] = ~m;                  // only unmasked and other classes
      pulse_evt(v, 2);
      apb_rd(a_cnt(n), rd); chk("R6 class sweep", rd, 32'd3);
    end
    for (int k = 0; k < 8; k++) apb_wr(a_sel(k), 32'h0);

    // R3: unmapped addresses read zero
    apb_rd(12'h0A0, rd); chk("R3 slot past end", rd, 32'h0);
    apb_rd(12'h200, rd); chk("R3 unmapped", rd, 32'h0);
    apb_rd(12'h004, rd); chk("R3 gap", rd, 32'h0);

    // R5: exhaustive level / scope / direction sweep
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 8; s++) begin
        for (int l = 0; l < 8; l++) begin
          int exp;
          logic [NCLS*16-1:0] v;
          exp = (d == 1) ? ((l > s) ? 2 : 0) : ((l <= s) ? 2 : 0);
          apb_wr(a_cnt(2), 32'h0);
          apb_wr(a_sel(2), mk_sel(16'h0001, 3, s, d[0], 1'b0));
          exec_lvl = 3'(l);
          v = '0; v[3*16] = 1'b1;
          pulse_evt(v, 2);
          apb_rd(a_cnt(2), rd); chk("R5 privilege gate", rd, 32'(exp));
        end
      end
    end
    exec_lvl = 3'd0;
    apb_wr(a_sel(2), 32'h0);

    // R10: write in the same cycle as an event
    apb_wr(a_sel(1), mk_sel(16'h0001, 0, 7, 1'b0, 1'b0));
    @(negedge clk);
    evt_vec = '0; evt_vec[0] = 1'b1;
    apb_wr(a_cnt(1), 32'd100);
    evt_vec = '0;
    apb_rd(a_cnt(1), rd); chk("R10 write priority", rd, 32'd100);

    // R7 / R8 / R9: overflow with interrupt enabled, PC taken at the wrap cycle
    apb_wr(a_sel(1), 32'h0);
    apb_wr(a_cnt(0), 32'hFFFF_FFFE);
    apb_wr(a_sel(0), mk_sel(16'h0001, 0, 7, 1'b0, 1'b1));
    @(negedge clk);
    cur_pc = 32'hA000_0004; evt_vec[0] = 1'b1;
    @(negedge clk);
    cur_pc = 32'hB000_0008;
    @(negedge clk);
    cur_pc = 32'hC000_000C; evt_vec = '0;
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    apb_rd(a_st(0), rd);  chk("R8 status", rd, 32'h11);
    apb_rd(a_cnt(0), rd); chk("R7 wrapped", rd, 32'h0);
    apb_rd(12'h010, rd);  chk("R9 pc capture", rd, 32'hB000_0008);
    apb_wr(12'h010, 32'h1234_5678);
    apb_rd(12'h010, rd);  chk("R9 read only", rd, 32'hB000_0008);
    pulse_evt({{(NCLS-1)*16{1'b0}}, 16'h0001}, 3);
    apb_rd(a_st(0), rd);  chk("R7 sticky", rd, 32'h11);
    apb_rd(a_cnt(0), rd); chk("R7 counts on", rd, 32'h3);
    apb_wr(a_st(0), 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    apb_rd(a_st(0), rd);  chk("R7 cleared", rd, 32'h0);
    apb_wr(a_sel(0), 32'h0);

    // R11: overflow with interrupt disabled
    apb_wr(a_cnt(6), 32'hFFFF_FFFF);
    apb_wr(a_sel(6), mk_sel(16'h0100, 9, 7, 1'b0, 1'b0));
    cur_pc = 32'hD000_0010;
    begin
      logic [NCLS*16-1:0] v;
      v = '0; v[9*16 + 8] = 1'b1;
      pulse_evt(v, 1);
    end
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    apb_rd(a_st(6), rd);  chk("R11 status", rd, 32'h1);
    apb_rd(12'h010, rd);  chk("R11 pc kept", rd, 32'hB000_0008);

    done = 1'b1;
    finish_run();
  end

endmodule